// File: doc/BRIEF.md
# Request-Grant Liveness Monitor

A passive checker that sits on the request and grant wires of a small synchronous arbiter that shares one resource among several requesters (three by default). It drives nothing back into the arbiter. While reset is low it tracks, for each requester separately, whether a request is still waiting for its grant. It also counts how many clock cycles that request has waited.

A strict run-time check of "every request is eventually granted" can never fail in finite time. The monitor therefore replaces "eventually" with a bound, `MAX_WAIT`. A request that has waited more than `MAX_WAIT` cycles raises a single error output. That output stays high until reset. The `STRICT` parameter sets what happens to a request that is withdrawn before it is granted. With `STRICT` = 1 the request stays owed and keeps counting. With `STRICT` = 0 it is forgotten.

Top module: `grant_liveness_monitor`

## Requirements
- R1: A high `rst` sampled at a rising edge clears `error` and every waiting record at that edge, so `error` reads 0 after it.
- R2: A request held with no grant for `MAX_WAIT` consecutive cycles leaves `error` at 0. If it is still waiting on cycle `MAX_WAIT`+1, `error` reads 1 after that edge.
- R3: A grant sampled for requester i clears that requester's wait count. A grant in the same cycle as a new request counts as service and leaves nothing waiting.
- R4: Each requester's wait is counted independently. A grant to one requester does not affect another requester's count, and concurrent waits are each bounded on their own.
- R5: Once `error` is 1, it stays 1 whatever the request and grant inputs do, until R1 applies.
- R6: With `STRICT` = 1, a request that drops before it is granted stays waiting. Its count keeps rising until a grant to that requester is sampled.
- R7: With `STRICT` = 0, a request that drops before it is granted is discarded, and its count returns to zero.
- R8: Requests sampled while `rst` is high start no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N_REQ | Request line per requester, bit i for requester i |
| gnt | input | N_REQ | Grant line per requester, bit i for requester i |
| error | output | 1 | Sticky flag for a wait bound that was exceeded |

## Verification
Every input is sampled at a rising edge, and `error` is a register, so the effect of a cycle's request and grant values shows on `error` just after that same edge. The bench drives the inputs shortly after one edge. It then waits for the next edge and compares `error` 1 ns later against a bench model that it advances with the same values. For a request held from the first cycle, the bound is therefore visible on the output after exactly `MAX_WAIT`+1 edges.

// File: rtl/grant_liveness_monitor.sv
module grant_liveness_monitor #(
  parameter int N_REQ    = 3,
  parameter int MAX_WAIT = 8,
  parameter bit STRICT   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req,
  input  logic [N_REQ-1:0] gnt,
  output logic             error
);

  localparam int            CW    = $clog2(MAX_WAIT + 2);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_WAIT + 1);
  localparam logic [CW-1:0] EDGE  = CW'(MAX_WAIT);

  logic [N_REQ-1:0] pend, hold, over, sat;
  logic [CW-1:0]    cnt [N_REQ];

  for (genvar i = 0; i < N_REQ; i++) begin : g_req
    assign hold[i] = !gnt[i] && (req[i] || (STRICT && pend[i]));
    assign over[i] = hold[i] && (cnt[i] >= EDGE);
    assign sat[i]  = (cnt[i] == LIMIT);

    always_ff @(posedge clk) begin
      if (rst || !hold[i]) begin
        pend[i] <= 1'b0;
        cnt[i]  <= '0;
      end else begin
        pend[i] <= 1'b1;
        cnt[i]  <= sat[i] ? LIMIT : cnt[i] + 1'b1;
      end
    end

    p_grant_clears_r3: assert property (@(posedge clk) disable iff (rst)
      gnt[i] |=> (cnt[i] == '0) && !pend[i]);

    p_strict_keeps_r6: assert property (@(posedge clk) disable iff (rst)
      (STRICT && pend[i] && !req[i] && !gnt[i]) |=> pend[i]);

    p_lenient_drops_r7: assert property (@(posedge clk) disable iff (rst)
      (!STRICT && !req[i]) |=> (cnt[i] == '0));

    p_bounded_count_r4: assert property (@(posedge clk) disable iff (rst)
      cnt[i] <= LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst)        error <= 1'b0;
    else if (|over) error <= 1'b1;
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> !error);

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    error |=> error);

  p_error_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> (|sat));

endmodule

// File: tb/grant_liveness_monitor_tb.sv
`timescale 1ns/1ps
module grant_liveness_monitor_tb;
  localparam int N  = 3;
  localparam int MW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] gnt = '0;
  logic err_s, err_l;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int cnt_s [N];
  int cnt_l [N];
  bit pend_s [N];
  bit exp_s = 1'b0;
  bit exp_l = 1'b0;

  always #4 clk = ~clk;

  grant_liveness_monitor #(.N_REQ(N), .MAX_WAIT(MW), .STRICT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .req(req), .gnt(gnt), .error(err_s));

  grant_liveness_monitor #(.N_REQ(N), .MAX_WAIT(MW), .STRICT(1'b0)) u_dut_lenient (
    .clk(clk), .rst(rst), .req(req), .gnt(gnt), .error(err_l));

  function automatic int bump(int c);
    return (c > MW) ? MW + 1 : c + 1;
  endfunction

  task automatic model_edge();
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        cnt_s[i] = 0; cnt_l[i] = 0; pend_s[i] = 1'b0;
      end else begin
        if (!gnt[i] && (req[i] || pend_s[i])) begin
          pend_s[i] = 1'b1; cnt_s[i] = bump(cnt_s[i]);
        end else begin
          pend_s[i] = 1'b0; cnt_s[i] = 0;
        end
        cnt_l[i] = (!gnt[i] && req[i]) ? bump(cnt_l[i]) : 0;
        if (cnt_s[i] > MW) exp_s = 1'b1;
        if (cnt_l[i] > MW) exp_l = 1'b1;
      end
    end
    if (rst) begin exp_s = 1'b0; exp_l = 1'b0; end
  endtask

  task automatic check(input string tag, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: error=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] g, input string tag);
    req = r; gnt = g;
    @(posedge clk);
    model_edge();
    #1;
    check({tag, " strict"}, err_s, exp_s);
    check({tag, " lenient"}, err_l, exp_l);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step('1, '0, "R1 R8 reset");
    step('1, '0, "R1 R8 reset");
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] want;
    logic [N-1:0] g;
    int ptr;
    void'($urandom(32'd20240601));
    for (int i = 0; i < N; i++) begin cnt_s[i] = 0; cnt_l[i] = 0; pend_s[i] = 0; end

    // R1 R8: reset state while requests are high
    @(negedge clk);
    do_reset();
    step('0, '0, "R1 idle after reset");

    // R2: bound boundary on one requester, then R5 sticky
    for (int k = 1; k <= MW + 1; k++) step(3'b100, '0, "R2 bound");
    for (int k = 0; k < 6; k++) step(3'($urandom), 3'($urandom), "R5 sticky");
    do_reset();

    // R3: grant with request and grant before bound
    for (int k = 0; k < 20; k++) step(3'b111, 3'b111, "R3 same-cycle grant");
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < MW; j++) step(3'b010, '0, "R3 wait");
      step(3'b010, 3'b010, "R3 grant");
    end

    // R4: independent waits
    for (int k = 0; k < 5; k++) step(3'b011, '0, "R4 concurrent");
    step(3'b011, 3'b001, "R4 grant other");
    for (int k = 0; k < 5; k++) step(3'b011, '0, "R4 independent");
    do_reset();

    // R6 R7: withdrawn request
    for (int k = 0; k < 3; k++) step(3'b010, '0, "R6 R7 raise");
    for (int k = 0; k < 7; k++) step('0, '0, "R6 R7 withdrawn");
    do_reset();

    // R3 R4: fair round-robin arbiter, random arrivals
    want = '0; ptr = 0;
    for (int k = 0; k < 2000; k++) begin
      want |= 3'($urandom);
      g = '0;
      for (int j = 0; j < N; j++)
        if (g == '0 && want[(ptr + j) % N]) begin
          g[(ptr + j) % N] = 1'b1;
          ptr = (ptr + j + 1) % N;
        end
      step(want, g, "R3 R4 fair");
      want &= ~g;
    end
    check("R4 fair no error", err_s, 1'b0);
    do_reset();

    // R2 R6 R7: starving arbiter, requester 2 never served, random drops
    for (int k = 0; k < 400; k++) begin
      g = 3'($urandom) & 3'b011;
      step(3'($urandom), g, "R2 R6 R7 starve");
      if (k % 100 == 99) do_reset();
    end
    for (int k = 0; k <= MW; k++) step(3'b100, 3'b011, "R2 starve held");
    check("R2 starve error", err_s, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule